// File: doc/BRIEF.md
# Feed-Committed PLL Control Registers

This block holds the software-visible settings for a secondary clock multiplier. It has two writable words. The first is a control word with an enable bit and a connect bit. The second is a configuration word with a multiplier field M and a divider field P. Bus writes only land in a pending copy of these settings. The pending copy is loaded into the active copy only when software completes an unlock feed on a dedicated feed address: a write whose low byte is 0xAA, then a write whose low byte is 0x55.

The PLL enable, connect, multiplier and divider outputs come from the active copy and from nothing else. A read-only status word reports the active fields and the live lock input. Software can therefore see which values the PLL is really using, while the control and configuration addresses read back the pending values.

Lock is an input that the block only reports. It never gates a commit and never changes the outputs.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, every pending and active field is 0. All PLL outputs are low or zero, and reads of the control, configuration and status words return 0 apart from the lock bit.
- R2: A write to word index 0 (control) stores bit 0 as pending enable and bit 1 as pending connect. A read of index 0 returns these two bits, with zeros in bits 31:2.
- R3: A write to word index 1 (configuration) stores bits 4:0 as pending M and bits 6:5 as pending P. A read of index 1 returns them, with zeros in bits 31:7.
- R4: Writes to the control or configuration word leave the PLL outputs and the status word unchanged until a valid feed completes.
- R5: A valid feed is two writes to word index 3: first one with low byte 0xAA, then one with low byte 0x55. Idle cycles may separate them. At the clock edge of the 0x55 write, all four pending fields are copied to the active fields.
- R6: Any bus write between the 0xAA and 0x55 writes aborts the feed, whether it goes to another address or carries another feed value. A 0x55 write that does not follow an armed 0xAA commits nothing. Upper data bits of a feed write are not compared.
- R7: The connect output is high only when both the active enable bit and the active connect bit are set.
- R8: Lock is never consulted. Connect commits while lock is low, and a falling lock leaves every output as it was.
- R9: A read of word index 2 (status) returns active M in bits 4:0, active P in bits 6:5, active enable in bit 8, active connect in bit 9 and the live lock input in bit 10. All other bits read 0.
- R10: Writes to the status index, or to any index above 3, change no pending or active field. Reads of the feed index and of unused indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Word index of the access |
| busWe | input | 1 | Write strobe, one write per high cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| pllLock | input | 1 | Lock indication from the PLL |
| pllEnableOut | output | 1 | Active enable |
| pllConnectOut | output | 1 | Active enable AND active connect |
| pllMultOut | output | 5 | Active multiplier M |
| pllDivOut | output | 2 | Active divider P |

## Verification
The assertions assume that the bus presents at most one write per cycle and that address and data are stable when the clock rises. They also assume that lock may change in any cycle without any relation to the outputs. The stimulus drives every access half a cycle before the rising edge and releases the write strobe after one edge. Lock toggles at random, independently of the feed state. The random traffic weights feed writes towards 0xAA and 0x55 so that both complete feeds and aborted feeds occur often.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
  localparam int M_W = 5;
  localparam int P_W = 2;
  localparam int CTRL_IDX = 0;
  localparam int CFG_IDX = 1;
  localparam int STAT_IDX = 2;
  localparam int FEED_IDX = 3;
  localparam int STAT_EN_BIT = 8;
  localparam int STAT_CN_BIT = 9;
  localparam int STAT_LK_BIT = 10;
  localparam logic [7:0] KEY_ARM = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;

  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic commit;
  } pll_strobe_t;

  typedef struct packed {
    logic           en;
    logic           cn;
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
  } pll_fields_t;
endpackage

// File: rtl/pll_feed_ctrl.sv
module pll_feed_ctrl
  import pll_feed_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        keyByte,
  output pll_strobe_t       strobes,
  output logic              armedQ
);
  logic isFeed;
  logic armedD;

  assign isFeed = busWe && (busAddr == ADDR_W'(FEED_IDX));

  always_comb begin
    strobes.wrCtrl = busWe && (busAddr == ADDR_W'(CTRL_IDX));
    strobes.wrCfg  = busWe && (busAddr == ADDR_W'(CFG_IDX));
    strobes.commit = isFeed && armedQ && (keyByte == KEY_FIRE);
  end

  // any write re-evaluates the arm flag; only an 0xAA feed write sets it
  always_comb begin
    armedD = armedQ;
    if (busWe) armedD = isFeed && (keyByte == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= armedD;
  end
endmodule

// File: rtl/pll_feed_dp.sv
module pll_feed_dp
  import pll_feed_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pll_strobe_t          strobes,
  input  logic [M_W+P_W-1:0]   fieldData,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 lockIn,
  output pll_fields_t          pendQ,
  output pll_fields_t          actQ,
  output logic [DATA_W-1:0]    rdData
);
  localparam int CFG_W = M_W + P_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        pendQ.en <= fieldData[0];
        pendQ.cn <= fieldData[1];
      end
      if (strobes.wrCfg) begin
        pendQ.m <= fieldData[M_W-1:0];
        pendQ.p <= fieldData[CFG_W-1:M_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               actQ <= '0;
    else if (strobes.commit) actQ <= pendQ;
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_W'(CTRL_IDX): rdData[1:0] = {pendQ.cn, pendQ.en};
      ADDR_W'(CFG_IDX):  rdData[CFG_W-1:0] = {pendQ.p, pendQ.m};
      ADDR_W'(STAT_IDX): begin
        rdData[CFG_W-1:0]  = {actQ.p, actQ.m};
        rdData[STAT_EN_BIT] = actQ.en;
        rdData[STAT_CN_BIT] = actQ.cn;
        rdData[STAT_LK_BIT] = lockIn;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pll_feed_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              pllLock,
  output logic              pllEnableOut,
  output logic              pllConnectOut,
  output logic [M_W-1:0]    pllMultOut,
  output logic [P_W-1:0]    pllDivOut
);
  pll_strobe_t strobes;
  pll_fields_t pendQ;
  pll_fields_t actQ;
  logic        armedQ;

  pll_feed_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .keyByte(busWdata[7:0]), .strobes(strobes), .armedQ(armedQ)
  );

  pll_feed_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fieldData(busWdata[M_W+P_W-1:0]), .rdAddr(busAddr), .lockIn(pllLock),
    .pendQ(pendQ), .actQ(actQ), .rdData(busRdata)
  );

  assign pllEnableOut  = actQ.en;
  assign pllConnectOut = actQ.en && actQ.cn;
  assign pllMultOut    = actQ.m;
  assign pllDivOut     = actQ.p;
endmodule

// File: rtl/pll_feed_chk.sv
module pll_feed_chk
  import pll_feed_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              pllLock,
  input logic              pllEnableOut,
  input logic              pllConnectOut,
  input logic [M_W-1:0]    pllMultOut,
  input logic [P_W-1:0]    pllDivOut,
  input pll_strobe_t       strobes,
  input pll_fields_t       pendQ,
  input logic              armedQ
);
  logic fireWr;
  assign fireWr = busWe && (busAddr == ADDR_W'(FEED_IDX)) && (busWdata[7:0] == KEY_FIRE);

  p_hold_outputs_r4: assert property (@(posedge clk) disable iff (!rstN)
    !fireWr |=> $stable({pllEnableOut, pllConnectOut, pllMultOut, pllDivOut}));

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (pllMultOut == $past(pendQ.m)) && (pllDivOut == $past(pendQ.p))
                       && (pllEnableOut == $past(pendQ.en)));

  p_abort_other_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != ADDR_W'(FEED_IDX)) |=> !armedQ);

  p_connect_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    pllConnectOut |-> pllEnableOut);

  p_lock_live_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(STAT_IDX)) |-> (busRdata[STAT_LK_BIT] == pllLock));

  p_lock_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pllLock) && !fireWr) |=> $stable(pllConnectOut));
endmodule

bind pll_feed_regs pll_feed_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .pllLock(pllLock), .pllEnableOut(pllEnableOut),
  .pllConnectOut(pllConnectOut), .pllMultOut(pllMultOut), .pllDivOut(pllDivOut),
  .strobes(strobes), .pendQ(pendQ), .armedQ(armedQ)
);

// File: tb/pll_feed_regs_tb.sv
module pll_feed_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  busAddr = 0;
  logic        busWe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic        pllLock = 0;
  logic        pllEnableOut, pllConnectOut;
  logic [4:0]  pllMultOut;
  logic [1:0]  pllDivOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model
  logic pEn = 0, pCn = 0, aEn = 0, aCn = 0, armed = 0;
  logic [4:0] pM = 0, aM = 0;
  logic [1:0] pP = 0, aP = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_feed_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .pllLock(pllLock), .pllEnableOut(pllEnableOut),
    .pllConnectOut(pllConnectOut), .pllMultOut(pllMultOut), .pllDivOut(pllDivOut)
  );

  function automatic logic [31:0] expRead(input logic [3:0] a, input logic lk);
    logic [31:0] v = '0;
    case (a)
      4'd0: v[1:0] = {pCn, pEn};
      4'd1: v[6:0] = {pP, pM};
      4'd2: begin v[6:0] = {aP, aM}; v[8] = aEn; v[9] = aCn; v[10] = lk; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [8:0] expOuts();
    return {aEn, aEn & aCn, aM, aP};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [3:0] a, input logic [31:0] d);
    if (a == 4'd0) begin pEn = d[0]; pCn = d[1]; end
    if (a == 4'd1) begin pM = d[4:0]; pP = d[6:5]; end
    if (a == 4'd3 && armed && d[7:0] == 8'h55) begin
      aEn = pEn; aCn = pCn; aM = pM; aP = pP;
    end
    armed = (a == 4'd3) && (d[7:0] == 8'hAA);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    busAddr = a; busWe = 1; busWdata = d;
    @(negedge clk);
    busWe = 0;
    modelWrite(a, d);
    check(req, 32'({pllEnableOut, pllConnectOut, pllMultOut, pllDivOut}), 32'(expOuts()));
  endtask

  task automatic doRead(input logic [3:0] a, input string req);
    @(negedge clk);
    busWe = 0; busAddr = a;
    #1;
    check(req, busRdata, expRead(a, pllLock));
  endtask

  task automatic feed();
    doWrite(4'd3, 32'hAA, "R5 arm");
    doWrite(4'd3, 32'h55, "R5 fire");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", 32'({pllEnableOut, pllConnectOut, pllMultOut, pllDivOut}), 0);
    rstN = 1;
    doRead(4'd0, "R1 ctrl");
    doRead(4'd1, "R1 cfg");
    doRead(4'd2, "R1 status");

    // R2/R3 pending with reserved bits, R4 outputs held
    doWrite(4'd0, 32'hFFFF_FFFF, "R4 ctrl write no effect");
    doWrite(4'd1, 32'hFFFF_FF96, "R4 cfg write no effect");
    doRead(4'd0, "R2 pending ctrl");
    doRead(4'd1, "R3 pending cfg");
    doRead(4'd2, "R4 status unchanged");

    // R8 commit connect with lock low
    pllLock = 0;
    feed();
    doRead(4'd2, "R9 status after feed");
    check("R8 connect without lock", 32'(pllConnectOut), 1);

    // R8 lock rise then fall: nothing changes
    @(negedge clk); pllLock = 1;
    doRead(4'd2, "R9 lock bit live");
    @(negedge clk); pllLock = 0;
    @(negedge clk);
    check("R8 lock drop keeps connect", 32'(pllConnectOut), 1);

    // R7 connect pending without enable
    doWrite(4'd0, 32'h2, "R4 ctrl");
    feed();
    check("R7 connect gated", 32'(pllConnectOut), 0);
    doRead(4'd2, "R7 status connect bit");

    // R6 aborts
    doWrite(4'd1, 32'h0000_0033, "R4 cfg");
    doWrite(4'd3, 32'hAA, "R6 arm");
    doWrite(4'd0, 32'h1, "R6 intervening write");
    doWrite(4'd3, 32'h55, "R6 abort by other write");
    doWrite(4'd3, 32'hAA, "R6 arm");
    doWrite(4'd3, 32'h12, "R6 wrong key");
    doWrite(4'd3, 32'h55, "R6 abort by wrong key");
    doWrite(4'd3, 32'h55, "R6 lone fire");
    // R6 upper bits ignored, idle gap allowed
    doWrite(4'd3, 32'h1234_56AA, "R6 arm upper bits");
    repeat (3) @(negedge clk);
    doWrite(4'd3, 32'hFFFF_FF55, "R5 fire after idle");

    // R10 status and unused writes ignored
    doWrite(4'd2, 32'hFFFF_FFFF, "R10 status write");
    doWrite(4'd9, 32'hFFFF_FFFF, "R10 unused write");
    doRead(4'd3, "R10 feed reads zero");
    doRead(4'd12, "R10 unused reads zero");
    doRead(4'd0, "R10 ctrl untouched");
    doRead(4'd1, "R10 cfg untouched");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      d = $urandom;
      if (sel < 2) a = 4'd0;
      else if (sel < 4) a = 4'd1;
      else if (sel < 8) begin
        a = 4'd3;
        case ($urandom_range(0, 3))
          0, 1: d[7:0] = 8'hAA;
          2: d[7:0] = 8'h55;
          default: ;
        endcase
        if (armed && $urandom_range(0, 1) == 1) d[7:0] = 8'h55;
      end else a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) pllLock = ~pllLock;
      doWrite(a, d, "R5 random");
      if (i % 7 == 0) doRead(4'($urandom_range(0, 4)), "R9 random read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule